// File: doc/BRIEF.md
# Nonvolatile Memory Command Launcher

This block sits in front of an on-chip nonvolatile memory array and decides whether each command byte may start an array operation. It decodes the byte and checks it against a permission policy. The policy takes into account a security latch and a mode input that says whether the part runs in its restricted single-chip mode. A permitted command raises a one-cycle launch strobe, together with the command code, toward a behavioural array model. A refused command raises an access error flag instead.

The security latch is set out of reset. It can be cleared in two ways: by presenting a backdoor key of four 16-bit words in order, or by completing a successful mass erase. A single wrong key word ends the key attempt until the next reset. The array's operation time is modelled by a busy counter. A command-complete flag falls when a command launches and rises again when the counter runs out.

Top module: `nvm_cmd_gate`

## Requirements
- R1: After a synchronous reset (rst high on a clock edge), secured=1, busy=0, cmd_done=1, acc_err=0, launch=0 and launch_code=0.
- R2: Only the codes 0x20, 0x40, 0x60, 0x05 and 0x41 are recognised. On the edge that samples cmd_valid with any other code, acc_err becomes 1 and no launch follows.
- R3: With mode_restrict=1 and secured=1, the codes 0x20, 0x40, 0x60 and 0x05 are refused: acc_err becomes 1 on the sampling edge and launch stays 0.
- R4: Code 0x41 (mass erase) is launched when the block is idle, whatever the state of secured and mode_restrict.
- R5: With mode_restrict=0, every recognised code launches when the block is idle, even while secured=1.
- R6: While secured=1, key words sampled with key_valid=1 are compared with the stored key, word i being bits [16i+15:16i] of KEY_VALUE (first word 0xDEF0, then 0x9ABC, 0x5678, 0x1234 by default). When the fourth consecutive word matches, secured becomes 0 on that same edge. After that, restricted commands launch.
- R7: A key word that does not match locks the key check until reset. Later key words, even correct ones, leave secured at 1.
- R8: An accepted command gives launch=1 for exactly one cycle, starting the cycle after the sampling edge, with launch_code equal to the command. busy is 1 for BUSY_CYCLES cycles from that edge. cmd_done goes to 0 on that edge and returns to 1 on the edge where busy falls.
- R9: A command sampled while busy=1 sets acc_err and produces no launch. It does not change the remaining busy time.
- R10: A launched mass erase clears secured on the same edge that raises launch.
- R11: An accepted command clears acc_err on its sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command byte is presented this cycle |
| cmd_code | input | 8 | Command byte |
| mode_restrict | input | 1 | 1 = restricted single-chip mode, so the secure-state check applies |
| key_valid | input | 1 | A backdoor key word is presented this cycle |
| key_word | input | 16 | Backdoor key word |
| launch | output | 1 | One-cycle strobe that starts the array operation |
| launch_code | output | 8 | Code of the most recently launched command |
| busy | output | 1 | The array model is running an operation |
| cmd_done | output | 1 | The last launched command has completed |
| acc_err | output | 1 | The most recent command was refused |
| secured | output | 1 | Security latch |

## Verification
A security latch stuck at the wrong value shows up on the secured output on the very next edge. It also shows up as a launch or an acc_err that has the wrong sign for the next restricted command. A key index that is off by one clears secured one word too early or too late, or fails to clear it at all. The bench catches this in the cycle of the fourth key word. A busy counter that is off by one moves the rising edge of cmd_done by one cycle. It also changes whether a command issued at the boundary is refused. The bench compares every output against its reference model on every clock, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/nvm_gate_pkg.sv
package nvm_gate_pkg;
  typedef enum logic [7:0] {
    OP_PROG    = 8'h20,
    OP_SERASE  = 8'h40,
    OP_SMOD    = 8'h60,
    OP_EVERIFY = 8'h05,
    OP_MERASE  = 8'h41
  } nvm_op_e;

  function automatic logic op_known(input logic [7:0] c);
    case (c)
      OP_PROG, OP_SERASE, OP_SMOD, OP_EVERIFY, OP_MERASE: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
  import nvm_gate_pkg::*;
(
  input  logic [7:0] code,
  input  logic       restrict_mode,
  input  logic       secured,
  output logic       known,
  output logic       mass,
  output logic       allowed
);
  always_comb begin
    known   = op_known(code);
    mass    = (code == OP_MERASE);
    // mass erase bypasses the secure-state restriction
    allowed = known && (mass || !restrict_mode || !secured);
  end
endmodule

// File: rtl/nvm_key_check.sv
module nvm_key_check #(
  parameter int KEY_WORDS = 4,
  parameter int KEY_W     = 16,
  parameter logic [KEY_WORDS*KEY_W-1:0] KEY_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_word,
  output logic             unlock
);
  localparam int IDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_WORDS - 1);

  logic [IDX_W-1:0] idx;
  logic             locked;
  logic             hit;
  logic             take;

  always_comb begin
    take   = enable && key_valid && !locked;
    hit    = (key_word == KEY_VALUE[idx*KEY_W +: KEY_W]);
    unlock = take && hit && (idx == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      locked <= 1'b0;
    end else if (take) begin
      if (!hit)              locked <= 1'b1;
      else if (idx == LAST)  idx    <= '0;
      else                   idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (start) begin
      cnt  <= CNT_W'(BUSY_CYCLES);
      done <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/nvm_cmd_gate.sv
module nvm_cmd_gate #(
  parameter int KEY_WORDS   = 4,
  parameter int KEY_W       = 16,
  parameter logic [KEY_WORDS*KEY_W-1:0] KEY_VALUE = 64'h1234_5678_9ABC_DEF0,
  parameter int BUSY_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic             mode_restrict,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_word,
  output logic             launch,
  output logic [7:0]       launch_code,
  output logic             busy,
  output logic             cmd_done,
  output logic             acc_err,
  output logic             secured
);
  logic known, mass, allowed, accept, unlock;

  nvm_cmd_decode u_dec (
    .code(cmd_code), .restrict_mode(mode_restrict), .secured(secured),
    .known(known), .mass(mass), .allowed(allowed)
  );

  nvm_key_check #(.KEY_WORDS(KEY_WORDS), .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_key (
    .clk(clk), .rst(rst), .enable(secured), .key_valid(key_valid),
    .key_word(key_word), .unlock(unlock)
  );

  assign accept = cmd_valid && !busy && allowed;

  nvm_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(accept), .busy(busy), .done(cmd_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      launch      <= 1'b0;
      launch_code <= '0;
      acc_err     <= 1'b0;
      secured     <= 1'b1;
    end else begin
      launch <= accept;
      if (accept) begin
        launch_code <= cmd_code;
        acc_err     <= 1'b0;
      end else if (cmd_valid) begin
        acc_err <= 1'b1;
      end
      if (unlock || (accept && mass)) secured <= 1'b0;
    end
  end
endmodule

// File: rtl/nvm_cmd_gate_chk.sv
module nvm_cmd_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       mode_restrict,
  input logic       launch,
  input logic       busy,
  input logic       cmd_done,
  input logic       acc_err,
  input logic       secured
);
  logic unknown_code;
  assign unknown_code = !(cmd_code == 8'h20 || cmd_code == 8'h40 || cmd_code == 8'h60 ||
                          cmd_code == 8'h05 || cmd_code == 8'h41);

  p_unknown_rejected_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && unknown_code) |=> (acc_err && !launch));

  p_secure_refuse_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && mode_restrict && secured && cmd_code == 8'h20) |=> (acc_err && !launch));

  p_mass_launch_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_code == 8'h41) |=> launch);

  p_mass_unsecures_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_code == 8'h41) |=> !secured);

  p_never_resecure_r6: assert property (@(posedge clk) disable iff (rst)
    !secured |=> !secured);

  p_launch_single_r8: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch);

  p_launch_busy_r8: assert property (@(posedge clk) disable iff (rst)
    launch |-> (busy && !cmd_done));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> (!launch && acc_err));
endmodule

bind nvm_cmd_gate nvm_cmd_gate_chk i_chk (.*);

// File: tb/test_nvm_cmd_gate.sv
module test_nvm_cmd_gate;
  localparam int N = 8;
  localparam logic [63:0] KEY = 64'h1234_5678_9ABC_DEF0;

  logic clk = 0, rst = 1, cmd_valid = 0, mode_restrict = 1, key_valid = 0;
  logic [7:0] cmd_code = 0;
  logic [15:0] key_word = 0;
  logic launch, busy, cmd_done, acc_err, secured;
  logic [7:0] launch_code;

  int checks = 0, failures = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0, m_idx = 0;
  bit m_lock = 0, m_sec = 1, m_done = 1, m_err = 0, m_launch = 0;
  logic [7:0] m_code = 0;

  always #2 clk = ~clk;

  nvm_cmd_gate i_nvm_cmd_gate (.*);

  function automatic bit known(input logic [7:0] c);
    return c == 8'h20 || c == 8'h40 || c == 8'h60 || c == 8'h05 || c == 8'h41;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_idx = 0; m_lock = 0; m_sec = 1; m_done = 1;
      m_err = 0; m_launch = 0; m_code = 0;
    end else begin
      bit ok, old_sec;
      old_sec = m_sec;
      ok = cmd_valid && m_cnt == 0 && known(cmd_code) &&
           (cmd_code == 8'h41 || !mode_restrict || !old_sec);
      m_launch = ok;
      if (ok) begin
        m_code = cmd_code; m_err = 0; m_done = 0; m_cnt = N;
        if (cmd_code == 8'h41) m_sec = 0;
      end else begin
        if (cmd_valid) m_err = 1;
        if (m_cnt > 0) begin
          m_cnt--;
          if (m_cnt == 0) m_done = 1;
        end
      end
      if (key_valid && old_sec && !m_lock) begin
        if (key_word != KEY[m_idx*16 +: 16]) m_lock = 1;
        else if (m_idx == 3) begin m_sec = 0; m_idx = 0; end
        else m_idx++;
      end
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", cur_req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("launch",      {7'b0, launch},   {7'b0, m_launch});
      chk("launch_code", launch_code,      m_code);
      chk("busy",        {7'b0, busy},     {7'b0, m_cnt != 0});
      chk("cmd_done",    {7'b0, cmd_done}, {7'b0, m_done});
      chk("acc_err",     {7'b0, acc_err},  {7'b0, m_err});
      chk("secured",     {7'b0, secured},  {7'b0, m_sec});
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; cmd_valid = 0; key_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic send_key(input logic [15:0] w);
    @(negedge clk); key_valid = 1; key_word = w;
    @(negedge clk); key_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    cur_req = "R1";
    #1;
    chk("reset secured", {7'b0, secured}, 8'd1);
    chk("reset busy", {7'b0, busy}, 8'd0);
    chk("reset done", {7'b0, cmd_done}, 8'd1);
    chk("reset err", {7'b0, acc_err}, 8'd0);
    chk("reset launch", {7'b0, launch}, 8'd0);
    idle(1);
    cur_req = "R2"; send_cmd(8'h33); send_cmd(8'h00); send_cmd(8'h21); idle(1);
    cur_req = "R3"; send_cmd(8'h20); send_cmd(8'h40); send_cmd(8'h60); send_cmd(8'h05); idle(1);
    cur_req = "R5"; mode_restrict = 0; send_cmd(8'h60); idle(1);
    cur_req = "R9"; send_cmd(8'h40); idle(N);
    cur_req = "R8"; send_cmd(8'h05); idle(N + 2);
    cur_req = "R11"; send_cmd(8'h77); send_cmd(8'h20); idle(N + 2);
    mode_restrict = 1;
    cur_req = "R7"; send_key(16'hDEF0); send_key(16'h1111);
    send_key(16'hDEF0); send_key(16'h9ABC); send_key(16'h5678); send_key(16'h1234);
    send_cmd(8'h20); idle(2);
    do_reset();
    cur_req = "R6"; send_key(16'hDEF0); send_key(16'h9ABC); send_key(16'h5678);
    send_key(16'h1234); idle(1); send_cmd(8'h40); idle(N + 2);
    do_reset();
    cur_req = "R4"; send_cmd(8'h41); idle(2);
    cur_req = "R10"; idle(N); send_cmd(8'h05); idle(N + 2);
    do_reset();
    cur_req = "R4"; mode_restrict = 0; send_cmd(8'h41); idle(N + 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule